// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Line Ownership

This block controls up to 32 general-purpose I/O lines from a 32-bit register bus. Every per-line control register exists twice: once in an open bank that any bus master may use, and once in a protected bank that responds only when a privilege input is high. A per-line ownership bit, held in the protected bank, decides which of the two banks controls each line. The owning bank can write that line's output value, drive enable, interrupt polarity, pending flag and interrupt enable, and it sees the line in its reads. The other bank leaves the line untouched on writes and reads a zero in its place.

Pin inputs pass through a two-stage synchroniser. Each line raises a sticky pending flag for as long as its synchronised input sits at the programmed active level. The flag is cleared by writing a one to it. Each bank has its own interrupt output: the OR, over the lines that bank owns, of pending flag AND interrupt enable. The bus uses word addresses: `bus_word` is the byte offset divided by four. A read returns its data on `bus_rdata` in the cycle after the request.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset, output values, drive enables, polarities, pending enables, pending flags and ownership are all zero, and `pin_out`, `pin_oe`, `irq_pub` and `irq_sec` are low.
- R2: The open bank uses word 0 (output), 1 (drive enable), 2 (input), 3 (polarity), 4 (pending flag) and 5 (interrupt enable), which are byte offsets 0x00 to 0x14. The protected bank uses the same order at words 8 to 13 (0x20 to 0x34). Ownership is at word 15 (0x3C). Words 6, 7 and 14 read as zero.
- R3: An ownership bit of 1 assigns the line to the open bank, and 0 assigns it to the protected bank. A bank's writes change only the lines it owns, and its reads return zero for the lines it does not own.
- R4: While `priv_ok` is low, writes to words 8 to 15 are ignored and reads of them return zero.
- R5: `pin_out` follows the output register and `pin_oe` follows the drive-enable register, where a 1 drives the pin.
- R6: A pin change is not seen by an input read captured at the first rising edge after the change. It is seen by a read captured at the third rising edge.
- R7: A polarity bit of 1 makes a high synchronised input active, and 0 makes a low input active. While a line is active, its pending flag is set on every cycle.
- R8: Writing 1 to a pending-flag bit clears it and writing 0 leaves it unchanged. If the line is still active, the set wins and the flag stays 1.
- R9: An interrupt-enable bit of 0 keeps that line's flag away from the interrupt outputs without clearing the flag.
- R10: `irq_pub` (or `irq_sec`) is the registered OR of flag AND enable over the lines owned by the open (or protected) bank. An ownership change moves a pending line's interrupt to the other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 4 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| priv_ok | input | 1 | Permission for protected-bank access |
| pin_in | input | NLINES | Asynchronous pin inputs |
| pin_out | output | NLINES | Output values |
| pin_oe | output | NLINES | Drive enables |
| irq_pub | output | 1 | Interrupt of the open bank |
| irq_sec | output | 1 | Interrupt of the protected bank |

## Verification
A wrong ownership bit shows at once, because reads of the affected line move from one bank to the other and a pending interrupt appears on the wrong output one cycle after the ownership write. A pending flag that clears while its line is still active, or that fails to set, shows in the next flag read and on the interrupt output two edges later. A protected write that gets through without permission changes `pin_out`, `pin_oe` or the ownership readback on the very next edge. A wrong synchroniser depth shifts the cycle in which an input read first sees a pin change.

// File: rtl/gpio_db_pkg.sv
package gpio_db_pkg;

  // Register selector within a bank (word address bits [2:0]).
  typedef enum logic [2:0] {
    SEL_OUT  = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_IN   = 3'd2,
    SEL_POL  = 3'd3,
    SEL_PEND = 3'd4,
    SEL_EN   = 3'd5,
    SEL_GAP  = 3'd6,
    SEL_OWN  = 3'd7
  } sel_e;

  typedef struct packed {
    logic hi_bank;
    sel_e sel;
  } decode_t;

  function automatic decode_t decode_word(input logic [3:0] w);
    decode_t d;
    d.hi_bank = w[3];
    d.sel     = sel_e'(w[2:0]);
    return d;
  endfunction

endpackage

// File: rtl/gpio_db_sync.sv
module gpio_db_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/gpio_db_regs.sv
module gpio_db_regs
  import gpio_db_pkg::*;
#(
  parameter int N  = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [3:0]    word,
  input  logic [DW-1:0] wdata,
  input  logic          priv_ok,
  input  logic [N-1:0]  sync_in,
  input  logic [N-1:0]  flag_q,
  output logic [N-1:0]  out_q,
  output logic [N-1:0]  dir_q,
  output logic [N-1:0]  pol_q,
  output logic [N-1:0]  en_q,
  output logic [N-1:0]  own_q,
  output logic [N-1:0]  clr,
  output logic [DW-1:0] rdata
);
  decode_t        dec;
  logic           allowed;
  logic           wr;
  logic           rd;
  logic [N-1:0]   reach;
  logic [N-1:0]   wbits;
  logic [DW-1:0]  view;

  assign dec     = decode_word(word);
  assign allowed = ~dec.hi_bank | priv_ok;
  assign wr      = req & we & allowed;
  assign rd      = req & ~we & allowed;
  // Lines this bank may touch: open bank owns 1-bits, protected bank 0-bits.
  assign reach   = dec.hi_bank ? ~own_q : own_q;
  assign wbits   = wdata[N-1:0];

  function automatic logic [N-1:0] merge(input logic [N-1:0] cur,
                                         input logic [N-1:0] nw,
                                         input logic [N-1:0] sel);
    return (cur & ~sel) | (nw & sel);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
      pol_q <= '0;
      en_q  <= '0;
      own_q <= '0;
    end else if (wr) begin
      case (dec.sel)
        SEL_OUT: out_q <= merge(out_q, wbits, reach);
        SEL_DIR: dir_q <= merge(dir_q, wbits, reach);
        SEL_POL: pol_q <= merge(pol_q, wbits, reach);
        SEL_EN:  en_q  <= merge(en_q, wbits, reach);
        SEL_OWN: if (dec.hi_bank) own_q <= wbits;
        default: ;
      endcase
    end
  end

  assign clr = (wr && dec.sel == SEL_PEND) ? (wbits & reach) : '0;

  always_comb begin
    view = '0;
    case (dec.sel)
      SEL_OUT:  view[N-1:0] = out_q & reach;
      SEL_DIR:  view[N-1:0] = dir_q & reach;
      SEL_IN:   view[N-1:0] = sync_in & reach;
      SEL_POL:  view[N-1:0] = pol_q & reach;
      SEL_PEND: view[N-1:0] = flag_q & reach;
      SEL_EN:   view[N-1:0] = en_q & reach;
      SEL_OWN:  view[N-1:0] = dec.hi_bank ? own_q : '0;
      default:  view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= view;
    else         rdata <= '0;
  end
endmodule

// File: rtl/gpio_db_irq.sv
module gpio_db_irq #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sync_in,
  input  logic [N-1:0] pol_q,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en_q,
  input  logic [N-1:0] own_q,
  output logic [N-1:0] flag_q,
  output logic         irq_pub,
  output logic         irq_sec
);
  logic [N-1:0] active;

  // Active when the synchronised level equals the programmed polarity.
  assign active = ~(sync_in ^ pol_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      irq_pub <= 1'b0;
      irq_sec <= 1'b0;
    end else begin
      flag_q  <= (flag_q & ~clr) | active;
      irq_pub <= |(flag_q & en_q & own_q);
      irq_sec <= |(flag_q & en_q & ~own_q);
    end
  end
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank #(
  parameter int NLINES = 32,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [3:0]        bus_word,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              priv_ok,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq_pub,
  output logic              irq_sec
);
  localparam int DW = 32;

  logic [NLINES-1:0] sync_q;
  logic [NLINES-1:0] out_q;
  logic [NLINES-1:0] dir_q;
  logic [NLINES-1:0] pol_q;
  logic [NLINES-1:0] en_q;
  logic [NLINES-1:0] own_q;
  logic [NLINES-1:0] clr;
  logic [NLINES-1:0] flag_q;

  gpio_db_sync #(.W(NLINES), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (sync_q)
  );

  gpio_db_regs #(.N(NLINES), .DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .req     (bus_req),
    .we      (bus_we),
    .word    (bus_word),
    .wdata   (bus_wdata),
    .priv_ok (priv_ok),
    .sync_in (sync_q),
    .flag_q  (flag_q),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .pol_q   (pol_q),
    .en_q    (en_q),
    .own_q   (own_q),
    .clr     (clr),
    .rdata   (bus_rdata)
  );

  gpio_db_irq #(.N(NLINES)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .sync_in (sync_q),
    .pol_q   (pol_q),
    .clr     (clr),
    .en_q    (en_q),
    .own_q   (own_q),
    .flag_q  (flag_q),
    .irq_pub (irq_pub),
    .irq_sec (irq_sec)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_req,
  input logic         bus_we,
  input logic [3:0]   bus_word,
  input logic         priv_ok,
  input logic [31:0]  bus_rdata,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe,
  input logic         irq_pub,
  input logic         irq_sec,
  input logic [N-1:0] own_q,
  input logic [N-1:0] en_q,
  input logic [N-1:0] flag_q,
  input logic [N-1:0] sync_q,
  input logic [N-1:0] pol_q
);
  // R1: reset leaves pins undriven and interrupts low
  p_reset_pins_r1: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && !irq_pub && !irq_sec));

  // R4: protected write without permission changes nothing
  p_denied_write_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_word[3] && !priv_ok) |=>
      ($stable(pin_out) && $stable(pin_oe) && $stable(own_q) && $stable(en_q)));

  // R4: protected read without permission returns zero
  p_denied_read_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_word[3] && !priv_ok) |=> (bus_rdata == '0));

  // R7: every line active in one cycle has its flag set in the next
  p_active_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(sync_q ^ pol_q) | flag_q) == {N{1'b1}}));

  // R9: with every enable clear, neither interrupt rises
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> (!irq_pub && !irq_sec));
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.N(NLINES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_word  (bus_word),
  .priv_ok   (priv_ok),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq_pub   (irq_pub),
  .irq_sec   (irq_sec),
  .own_q     (own_q),
  .en_q      (en_q),
  .flag_q    (flag_q),
  .sync_q    (sync_q),
  .pol_q     (pol_q)
);

// File: tb/tb_gpio_dual_bank.sv
module tb_gpio_dual_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  typedef struct packed {
    logic        we;
    logic [3:0]  w;
    logic [31:0] d;
    logic        p;
    logic [31:0] e;
    logic [7:0]  rq;
  } vec_t;

  // Pins held at 32'hA5A5_0F0F while the table runs.
  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'hF, 32'hFFFF0000, 1'b1, 32'h0,        8'd2},  // R2 own write
    '{1'b0, 4'hF, 32'h0,        1'b1, 32'hFFFF0000, 8'd2},  // R2
    '{1'b1, 4'h0, 32'h12345678, 1'b0, 32'h0,        8'd3},  // R3 open bank out
    '{1'b0, 4'h0, 32'h0,        1'b0, 32'h12340000, 8'd3},  // R3
    '{1'b1, 4'h8, 32'hAAAA5555, 1'b1, 32'h0,        8'd3},  // R3 protected out
    '{1'b0, 4'h8, 32'h0,        1'b1, 32'h00005555, 8'd3},  // R3
    '{1'b1, 4'h8, 32'hFFFFFFFF, 1'b0, 32'h0,        8'd4},  // R4 denied
    '{1'b0, 4'h8, 32'h0,        1'b1, 32'h00005555, 8'd4},  // R4
    '{1'b0, 4'h8, 32'h0,        1'b0, 32'h0,        8'd4},  // R4 denied read
    '{1'b0, 4'h2, 32'h0,        1'b0, 32'hA5A50000, 8'd6},  // R6 input view
    '{1'b0, 4'hA, 32'h0,        1'b1, 32'h00000F0F, 8'd6},  // R6
    '{1'b1, 4'h1, 32'h00FF0000, 1'b0, 32'h0,        8'd5},  // R5 drive enable
    '{1'b0, 4'h9, 32'h0,        1'b1, 32'h0,        8'd3},  // R3
    '{1'b0, 4'h1, 32'h0,        1'b0, 32'h00FF0000, 8'd5},  // R5
    '{1'b0, 4'h6, 32'h0,        1'b1, 32'h0,        8'd2},  // R2 gap
    '{1'b0, 4'h7, 32'h0,        1'b1, 32'h0,        8'd2},  // R2 gap
    '{1'b1, 4'hF, 32'h0,        1'b0, 32'h0,        8'd4},  // R4 denied own
    '{1'b0, 4'hF, 32'h0,        1'b1, 32'hFFFF0000, 8'd4},  // R4
    '{1'b0, 4'hF, 32'h0,        1'b0, 32'h0,        8'd4},  // R4
    '{1'b0, 4'hD, 32'h0,        1'b1, 32'h0,        8'd1}   // R1 enable reset
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 1'b0;
  logic          bus_we = 1'b0;
  logic [3:0]    bus_word = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          priv_ok = 1'b0;
  logic [N-1:0]  pin_in = 32'hA5A50F0F;
  logic [N-1:0]  pin_out;
  logic [N-1:0]  pin_oe;
  logic          irq_pub;
  logic          irq_sec;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_dual_bank #(.NLINES(N)) dut (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .priv_ok   (priv_ok),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_pub   (irq_pub),
    .irq_sec   (irq_sec)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Called just after a falling edge; returns after the next falling edge.
  task automatic bus(input logic we, input logic [3:0] w, input logic [31:0] d,
                     input logic p, output logic [31:0] r);
    bus_req = 1'b1; bus_we = we; bus_word = w; bus_wdata = d; priv_ok = p;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    r = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 irqs", {30'd0, irq_pub, irq_sec}, 32'h0);
    bus(1'b0, 4'h8, 32'h0, 1'b1, rd); chk("R1 out reset", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus(TBL[i].we, TBL[i].w, TBL[i].d, TBL[i].p, rd);
      if (!TBL[i].we) chk($sformatf("R%0d vec%0d", TBL[i].rq, i), rd, TBL[i].e);
    end
    chk("R5 pin_out", pin_out, 32'h12345555);
    chk("R5 pin_oe", pin_oe, 32'h00FF0000);

    // R7 active high on line 0, R8 clear loses to a live condition
    bus(1'b1, 4'hB, 32'h0000F0F1, 1'b1, rd);
    bus(1'b1, 4'hC, 32'hFFFFFFFF, 1'b1, rd);
    bus(1'b0, 4'hC, 32'h0, 1'b1, rd); chk("R7 high active persists", rd, 32'h1);
    // R8 clear once inactive
    bus(1'b1, 4'hB, 32'h0000F0F0, 1'b1, rd);
    bus(1'b1, 4'hC, 32'h0000FFFF, 1'b1, rd);
    bus(1'b0, 4'hC, 32'h0, 1'b1, rd); chk("R8 cleared", rd, 32'h0);
    // R7 active low on line 3, R9 masked
    pin_in = 32'hA5A50F07;
    idle(4);
    bus(1'b0, 4'hC, 32'h0, 1'b1, rd); chk("R7 low active", rd, 32'h8);
    chk("R9 masked irq_sec", {31'd0, irq_sec}, 32'h0);
    bus(1'b1, 4'hD, 32'h8, 1'b1, rd);
    idle(1);
    chk("R10 irq_sec on", {31'd0, irq_sec}, 32'h1);
    chk("R10 irq_pub off", {31'd0, irq_pub}, 32'h0);
    bus(1'b1, 4'hD, 32'h0, 1'b1, rd);
    idle(1);
    chk("R9 irq_sec off", {31'd0, irq_sec}, 32'h0);
    bus(1'b0, 4'hC, 32'h0, 1'b1, rd); chk("R9 flag kept", rd, 32'h8);
    pin_in = 32'hA5A50F0F;
    idle(4);
    bus(1'b1, 4'hC, 32'h0, 1'b1, rd);
    bus(1'b0, 4'hC, 32'h0, 1'b1, rd); chk("R8 zero write", rd, 32'h8);
    bus(1'b1, 4'hC, 32'h8, 1'b1, rd);
    bus(1'b0, 4'hC, 32'h0, 1'b1, rd); chk("R8 one write", rd, 32'h0);

    // R10 open bank interrupt on line 16
    bus(1'b1, 4'h3, 32'h5A5A0000, 1'b0, rd);
    bus(1'b1, 4'h4, 32'hFFFFFFFF, 1'b0, rd);
    bus(1'b1, 4'h5, 32'h00010000, 1'b0, rd);
    idle(2);
    chk("R10 irq_pub idle", {31'd0, irq_pub}, 32'h0);
    pin_in = 32'hA5A40F0F;
    idle(5);
    chk("R10 irq_pub on", {31'd0, irq_pub}, 32'h1);
    chk("R10 irq_sec off", {31'd0, irq_sec}, 32'h0);
    bus(1'b0, 4'h4, 32'h0, 1'b0, rd); chk("R3 open flag", rd, 32'h00010000);
    bus(1'b0, 4'hC, 32'h0, 1'b1, rd); chk("R3 hidden flag", rd, 32'h0);
    // R10 ownership move
    bus(1'b1, 4'hF, 32'hFFFE0000, 1'b1, rd);
    idle(1);
    chk("R10 moved pub", {31'd0, irq_pub}, 32'h0);
    chk("R10 moved sec", {31'd0, irq_sec}, 32'h1);

    // R6 synchroniser latency
    pin_in = 32'hA5A40F0E;
    bus(1'b0, 4'hA, 32'h0, 1'b1, rd); chk("R6 first edge", rd, 32'h00000F0F);
    idle(1);
    bus(1'b0, 4'hA, 32'h0, 1'b1, rd); chk("R6 third edge", rd, 32'h00000F0E);

    // R1 reset mid-run
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    chk("R1 rerst pins", pin_out | pin_oe, 32'h0);
    chk("R1 rerst irqs", {30'd0, irq_pub, irq_sec}, 32'h0);
    bus(1'b0, 4'hF, 32'h0, 1'b1, rd); chk("R1 rerst own", rd, 32'h0);

    summary();
    $finish;
  end
endmodule